// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block produces the main-domain reset outputs of a chip from two sources: the main-supply power-on-reset indication and an external active-low reset pin. It runs entirely on the slow clock. Both inputs pass through a synchronizer first. Each release then follows a fixed sequence: the processor clock is enabled for a short startup window, and the processor and peripheral resets are released at the end of it. A backup-domain reset output depends only on the backup reset input. A main-supply loss therefore leaves it and the mode settings untouched.

The mode settings are written through a simple write port. They hold a user-reset enable bit and a length field for the external reset output. When the main supply returns, the external reset output stays low for 2^(field+1) slow clock cycles. A status field reports which source caused the last completed reset.

Top module: `sysrst_ctrl`

## Requirements
- R1: While `por_act` is 1, `proc_rst_n`, `periph_rst_n` and `ext_rst_out_n` are 0 in the same cycle, and `bkp_dom_rst_n` remains 1.
- R2: After `por_act` falls, `proc_clk_en` is 1 after clock edges 3, 4 and 5, counted from the first edge that samples `por_act` low. `proc_rst_n` and `periph_rst_n` go to 1 after edge 6.
- R3: When a main-supply release completes, `rst_type` becomes 3'd1 on the same edge on which the processor reset is released.
- R4: After a main-supply release, `ext_rst_out_n` stays 0 through edge 3+N-1 and is 1 after edge 3+N, where N = 2^(mode_len+1). A field value of 0 gives N=2, 1 gives N=4 and 3 gives N=16.
- R5: The mode settings are not cleared by a main-supply power-on-reset. A length written before the supply loss governs the external reset pulse that follows it.
- R6: With the user-reset enable bit at 1, a low level on `ext_rst_pin_n` pulls `proc_rst_n` and `periph_rst_n` to 0 after the third edge. `ext_rst_out_n` stays 1 during the user reset.
- R7: When `ext_rst_pin_n` returns high, `proc_clk_en` is 1 after edges 3 to 5 counted from the first edge that samples the pin high. The resets are released after edge 6.
- R8: When a user reset completes, `rst_type` becomes 3'd4.
- R9: With the user-reset enable bit at 0, a low level on `ext_rst_pin_n` leaves `proc_rst_n`, `periph_rst_n` and `rst_type` unchanged.
- R10: A power-on-reset during a user reset takes priority. All main-domain outputs go low, and the following release runs the full main-supply sequence, which ends with `rst_type` = 3'd1.
- R11: While `bkp_rst_n` is 0, `bkp_dom_rst_n` is 0 and `rst_type` is 3'd0. The mode settings return to enable 0 and length 0. Once `bkp_rst_n` is released, the block runs the main-supply release sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock, the only clock of the block |
| bkp_rst_n | input | 1 | Synchronous active-low backup-domain reset |
| por_act | input | 1 | Main-supply power-on-reset indication, active high |
| ext_rst_pin_n | input | 1 | External reset pin level, active low, asynchronous |
| mode_wr | input | 1 | Write strobe for the mode settings |
| mode_usr_en | input | 1 | User-reset enable value to write |
| mode_len | input | LEN_W | External reset length field to write |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| ext_rst_out_n | output | 1 | External reset pin drive, active low |
| bkp_dom_rst_n | output | 1 | Backup-domain reset, active low |
| proc_clk_en | output | 1 | Processor clock enable during the startup window |
| rst_type | output | 3 | Last reset cause: 0 none, 1 main supply, 4 user |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a three-cycle startup window and a four-bit length field. With these values the edge counts in the requirements hold exactly. The length field is exercised at 0, 1 and 3, so pulses of 2, 4 and 16 cycles are measured. The shortest pulse ends before the processor reset is released and the longest ends well after it, so both orderings of the two outputs are covered.

// File: rtl/rstc_pkg.sv
// Shared types for the reset controller.
// Holds the sequencer state encoding and the reset cause codes reported in the status field.
package rstc_pkg;

    typedef enum logic [2:0] {
        ST_MAIN_OFF  = 3'd0,
        ST_WAKE_BOOT = 3'd1,
        ST_RUN       = 3'd2,
        ST_USER_HOLD = 3'd3,
        ST_USER_BOOT = 3'd4
    } rstc_state_t;

    localparam int CAUSE_W = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 3'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_WAKE = 3'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_USER = 3'd4;

endpackage

// File: rtl/rstc_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 1. After reset, the output and every stage hold RST_VAL.
module rstc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift the sampled level through the stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rstc_seq.sv
// Reset release sequencer.
// Tracks the main-supply and user reset phases and runs the startup window.
// Reports the cause when a release completes.
// Assumes synchronized inputs. The main-supply indication has priority in every state.
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int STARTUP_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_s,
    input  logic                pin_s,
    input  logic                usr_en,
    output rstc_state_t         st,
    output logic                boot_clk_en,
    output logic                wake_begin,
    output logic                done_vld,
    output logic [CAUSE_W-1:0]  done_code
);

    localparam int CNT_W = (STARTUP_CYC < 2) ? 1 : $clog2(STARTUP_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYC - 1);

    rstc_state_t      st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // Next-state and startup counter logic.
    always_comb begin
        st_nxt    = st;
        cnt_nxt   = cnt;
        done_vld  = 1'b0;
        done_code = CAUSE_NONE;
        if (por_s) begin
            st_nxt = ST_MAIN_OFF;
        end else begin
            case (st)
                ST_MAIN_OFF: begin
                    st_nxt  = ST_WAKE_BOOT;
                    cnt_nxt = '0;
                end
                ST_WAKE_BOOT, ST_USER_BOOT: begin
                    if (cnt == CNT_LAST) begin
                        st_nxt    = ST_RUN;
                        done_vld  = 1'b1;
                        done_code = (st == ST_WAKE_BOOT) ? CAUSE_WAKE : CAUSE_USER;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!pin_s && usr_en) st_nxt = ST_USER_HOLD;
                end
                ST_USER_HOLD: begin
                    if (pin_s) begin
                        st_nxt  = ST_USER_BOOT;
                        cnt_nxt = '0;
                    end
                end
                default: st_nxt = ST_MAIN_OFF;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_MAIN_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    assign boot_clk_en = (st == ST_WAKE_BOOT) || (st == ST_USER_BOOT);
    assign wake_begin  = (st == ST_MAIN_OFF) && !por_s;

endmodule

// File: rtl/rstc_ext_timer.sv
// External reset pulse timer.
// A load starts a count of 2^(len+1) cycles, and busy stays high until it runs out.
// Assumes LEN_W small enough that 2^(2^LEN_W) is a sane cycle count.
module rstc_ext_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             busy
);

    localparam int CW = (1 << LEN_W) + 2;

    logic [CW-1:0]  remain;
    logic [LEN_W:0] shamt;
    logic [CW-1:0]  span;

    // Length field to cycle count.
    always_comb begin
        shamt = {1'b0, len} + 1'b1;
        span  = CW'(1) << shamt;
    end

    // Down-counter that holds the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= '0;
        else if (load)        remain <= span;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/sysrst_ctrl.sv
// Multi-source system reset controller, top level.
// Synchronizes the supply and pin inputs and holds the backup-domain mode settings and cause status.
// Gates the main-domain outputs.
// Assumes one slow clock. bkp_rst_n is the only reset of the block's own state.
module sysrst_ctrl
    import rstc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STARTUP_CYC = 3,
    parameter int LEN_W       = 4
) (
    input  logic               clk_slow,
    input  logic               bkp_rst_n,
    input  logic               por_act,
    input  logic               ext_rst_pin_n,
    input  logic               mode_wr,
    input  logic               mode_usr_en,
    input  logic [LEN_W-1:0]   mode_len,
    output logic               proc_rst_n,
    output logic               periph_rst_n,
    output logic               ext_rst_out_n,
    output logic               bkp_dom_rst_n,
    output logic               proc_clk_en,
    output logic [CAUSE_W-1:0] rst_type
);

    logic               por_sync;
    logic               pin_sync;
    logic               usr_en_q;
    logic [LEN_W-1:0]   len_q;
    logic               bkp_q;
    rstc_state_t        seq_st;
    logic               boot_en;
    logic               wake_begin;
    logic               done_vld;
    logic [CAUSE_W-1:0] done_code;
    logic               ext_busy;

    rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_por_sync (
        .clk   (clk_slow),
        .rst_n (bkp_rst_n),
        .d     (por_act),
        .q     (por_sync)
    );

    rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk   (clk_slow),
        .rst_n (bkp_rst_n),
        .d     (ext_rst_pin_n),
        .q     (pin_sync)
    );

    rstc_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
        .clk         (clk_slow),
        .rst_n       (bkp_rst_n),
        .por_s       (por_sync),
        .pin_s       (pin_sync),
        .usr_en      (usr_en_q),
        .st          (seq_st),
        .boot_clk_en (boot_en),
        .wake_begin  (wake_begin),
        .done_vld    (done_vld),
        .done_code   (done_code)
    );

    rstc_ext_timer #(.LEN_W(LEN_W)) u_ext_timer (
        .clk   (clk_slow),
        .rst_n (bkp_rst_n),
        .load  (wake_begin),
        .len   (len_q),
        .busy  (ext_busy)
    );

    // Backup-domain mode settings, kept across supply loss.
    always_ff @(posedge clk_slow) begin
        if (!bkp_rst_n) begin
            usr_en_q <= 1'b0;
            len_q    <= '0;
        end else if (mode_wr) begin
            usr_en_q <= mode_usr_en;
            len_q    <= mode_len;
        end
    end

    // Cause status, updated when a release completes.
    always_ff @(posedge clk_slow) begin
        if (!bkp_rst_n)    rst_type <= CAUSE_NONE;
        else if (done_vld) rst_type <= done_code;
    end

    // Backup-domain reset output, driven only by the backup reset.
    always_ff @(posedge clk_slow) begin
        bkp_q <= bkp_rst_n;
    end

    assign proc_rst_n    = (seq_st == ST_RUN) && !por_act;
    assign periph_rst_n  = (seq_st == ST_RUN) && !por_act;
    assign ext_rst_out_n = !(por_act || (seq_st == ST_MAIN_OFF) || ext_busy);
    assign proc_clk_en   = boot_en;
    assign bkp_dom_rst_n = bkp_q;

endmodule

// File: rtl/rstc_chk.sv
// Property checker for sysrst_ctrl, attached through bind.
// Observes ports plus the synchronized supply level and the user enable.
module rstc_chk #(
    parameter int STARTUP_CYC = 3
) (
    input logic       clk,
    input logic       bkp_rst_n,
    input logic       por_act,
    input logic       por_s,
    input logic       usr_en_q,
    input logic       proc_rst_n,
    input logic       periph_rst_n,
    input logic       ext_rst_out_n,
    input logic       bkp_dom_rst_n,
    input logic       proc_clk_en,
    input logic [2:0] rst_type
);

    logic [15:0] run_len;

    // Count consecutive cycles with the clock enable high.
    always_ff @(posedge clk) begin
        if (!bkp_rst_n)       run_len <= '0;
        else if (proc_clk_en) run_len <= run_len + 1'b1;
        else                  run_len <= '0;
    end

    AST_POR_HOLDS_ALL: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        por_act |-> (!proc_rst_n && !periph_rst_n && !ext_rst_out_n)); // R1

    AST_BKP_OWN_RESET: assert property (@(posedge clk)
        !bkp_dom_rst_n |-> !$past(bkp_rst_n)); // R1

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        proc_clk_en |-> (run_len < STARTUP_CYC)); // R2

    AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        ($fell(proc_clk_en) && !$past(por_s)) |-> (run_len == STARTUP_CYC)); // R7

    AST_RELEASE_AFTER_BOOT: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        ($rose(proc_rst_n) && !$past(por_act)) |-> $past(proc_clk_en)); // R2

    AST_CAUSE_ON_RELEASE: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (!$stable(rst_type) && !por_act) |-> (proc_rst_n && !$past(proc_rst_n))); // R3

    AST_CAUSE_CODES: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        !$stable(rst_type) |-> (rst_type == 3'd1 || rst_type == 3'd4)); // R8

    AST_USER_NEEDS_EN: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        ($fell(proc_rst_n) && !por_act && !$past(por_s)) |-> $past(usr_en_q)); // R9

    AST_EXT_SUPPLY_ONLY: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        $fell(ext_rst_out_n) |-> (por_act || $past(por_s))); // R6

endmodule

bind sysrst_ctrl rstc_chk #(.STARTUP_CYC(STARTUP_CYC)) u_chk (
    .clk           (clk_slow),
    .bkp_rst_n     (bkp_rst_n),
    .por_act       (por_act),
    .por_s         (por_sync),
    .usr_en_q      (usr_en_q),
    .proc_rst_n    (proc_rst_n),
    .periph_rst_n  (periph_rst_n),
    .ext_rst_out_n (ext_rst_out_n),
    .bkp_dom_rst_n (bkp_dom_rst_n),
    .proc_clk_en   (proc_clk_en),
    .rst_type      (rst_type)
);

// File: tb/sysrst_ctrl_tb.sv
// Directed bench for sysrst_ctrl: one task per scenario, each checking its own results.
module sysrst_ctrl_tb;

    localparam int LEN_W = 4;

    logic             clk_slow = 1'b0;
    logic             bkp_rst_n;
    logic             por_act;
    logic             ext_rst_pin_n;
    logic             mode_wr;
    logic             mode_usr_en;
    logic [LEN_W-1:0] mode_len;
    logic             proc_rst_n;
    logic             periph_rst_n;
    logic             ext_rst_out_n;
    logic             bkp_dom_rst_n;
    logic             proc_clk_en;
    logic [2:0]       rst_type;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk_slow = ~clk_slow;

    sysrst_ctrl #(.SYNC_STAGES(2), .STARTUP_CYC(3), .LEN_W(LEN_W)) u_dut (
        .clk_slow      (clk_slow),
        .bkp_rst_n     (bkp_rst_n),
        .por_act       (por_act),
        .ext_rst_pin_n (ext_rst_pin_n),
        .mode_wr       (mode_wr),
        .mode_usr_en   (mode_usr_en),
        .mode_len      (mode_len),
        .proc_rst_n    (proc_rst_n),
        .periph_rst_n  (periph_rst_n),
        .ext_rst_out_n (ext_rst_out_n),
        .bkp_dom_rst_n (bkp_dom_rst_n),
        .proc_clk_en   (proc_clk_en),
        .rst_type      (rst_type)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk_slow);
        @(negedge clk_slow);
    endtask

    task automatic write_mode(input bit en, input int len);
        mode_wr     = 1'b1;
        mode_usr_en = en;
        mode_len    = LEN_W'(len);
        tick();
        mode_wr     = 1'b0;
    endtask

    // Follows a main-supply release once the caller has dropped the source at a negedge.
    task automatic watch_wake(input int n_ext, input string req);
        int last;
        last = (6 > 3 + n_ext) ? 6 : 3 + n_ext;
        for (int e = 1; e <= last + 1; e++) begin
            tick();
            chk(proc_clk_en == (e >= 3 && e <= 5), "R2 clk_en", proc_clk_en, (e >= 3 && e <= 5));
            chk(proc_rst_n == (e >= 6), "R2 proc_rst_n", proc_rst_n, (e >= 6));
            chk(periph_rst_n == (e >= 6), "R2 periph_rst_n", periph_rst_n, (e >= 6));
            chk(ext_rst_out_n == (e >= 3 + n_ext), req, ext_rst_out_n, (e >= 3 + n_ext));
            if (e == 6) chk(rst_type == 3'd1, "R3 cause wake", rst_type, 1);
        end
    endtask

    task automatic t_reset_and_first_wake();
        bkp_rst_n = 1'b0; por_act = 1'b1; ext_rst_pin_n = 1'b1;
        mode_wr = 1'b0; mode_usr_en = 1'b0; mode_len = '0;
        repeat (3) tick();
        chk(bkp_dom_rst_n == 1'b0, "R11 bkp out low", bkp_dom_rst_n, 0);
        chk(rst_type == 3'd0, "R11 cause none", rst_type, 0);
        bkp_rst_n = 1'b1;
        repeat (4) tick();
        chk(!proc_rst_n && !periph_rst_n && !ext_rst_out_n, "R1 held low",
            {proc_rst_n, periph_rst_n, ext_rst_out_n}, 0);
        chk(bkp_dom_rst_n == 1'b1, "R1 bkp untouched", bkp_dom_rst_n, 1);
        por_act = 1'b0;
        watch_wake(2, "R4 ext len0 (R11 default)");
    endtask

    task automatic t_user_disabled();
        ext_rst_pin_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(proc_rst_n && periph_rst_n, "R9 pin ignored", {proc_rst_n, periph_rst_n}, 3);
        end
        chk(rst_type == 3'd1, "R9 cause kept", rst_type, 1);
        ext_rst_pin_n = 1'b1;
        repeat (3) tick();
    endtask

    task automatic t_user_reset();
        write_mode(1'b1, 0);
        ext_rst_pin_n = 1'b0;
        for (int e = 1; e <= 5; e++) begin
            tick();
            chk(proc_rst_n == (e < 3), "R6 proc entry", proc_rst_n, (e < 3));
            chk(periph_rst_n == (e < 3), "R6 periph entry", periph_rst_n, (e < 3));
            chk(ext_rst_out_n == 1'b1, "R6 ext stays high", ext_rst_out_n, 1);
        end
        ext_rst_pin_n = 1'b1;
        for (int e = 1; e <= 7; e++) begin
            tick();
            chk(proc_clk_en == (e >= 3 && e <= 5), "R7 clk_en", proc_clk_en, (e >= 3 && e <= 5));
            chk(proc_rst_n == (e >= 6), "R7 proc exit", proc_rst_n, (e >= 6));
            chk(ext_rst_out_n == 1'b1, "R6 ext high on exit", ext_rst_out_n, 1);
        end
        chk(rst_type == 3'd4, "R8 cause user", rst_type, 4);
    endtask

    task automatic t_retained_len();
        write_mode(1'b1, 3);
        por_act = 1'b1;
        #1;
        chk(!proc_rst_n && !periph_rst_n && !ext_rst_out_n, "R1 immediate",
            {proc_rst_n, periph_rst_n, ext_rst_out_n}, 0);
        chk(bkp_dom_rst_n == 1'b1, "R1 bkp kept", bkp_dom_rst_n, 1);
        repeat (5) tick();
        por_act = 1'b0;
        watch_wake(16, "R5 ext len3 retained");
    endtask

    task automatic t_supply_over_user();
        ext_rst_pin_n = 1'b0;
        repeat (5) tick();
        chk(!proc_rst_n, "R10 in user reset", proc_rst_n, 0);
        por_act = 1'b1;
        #1;
        chk(!ext_rst_out_n, "R10 ext low", ext_rst_out_n, 0);
        repeat (4) tick();
        ext_rst_pin_n = 1'b1;
        repeat (4) tick();
        chk(!proc_clk_en && !proc_rst_n, "R10 held", {proc_clk_en, proc_rst_n}, 0);
        por_act = 1'b0;
        watch_wake(16, "R10 ext after priority");
    endtask

    task automatic t_len_one();
        write_mode(1'b1, 1);
        por_act = 1'b1;
        repeat (4) tick();
        por_act = 1'b0;
        watch_wake(4, "R4 ext len1");
    endtask

    task automatic t_backup_again();
        bkp_rst_n = 1'b0;
        repeat (2) tick();
        chk(bkp_dom_rst_n == 1'b0, "R11 bkp out low", bkp_dom_rst_n, 0);
        chk(rst_type == 3'd0, "R11 cause cleared", rst_type, 0);
        chk(!proc_rst_n, "R11 proc low", proc_rst_n, 0);
        bkp_rst_n = 1'b1;
        watch_wake(2, "R11 len cleared");
        chk(bkp_dom_rst_n == 1'b1, "R11 bkp out high", bkp_dom_rst_n, 1);
        ext_rst_pin_n = 1'b0;
        repeat (6) tick();
        chk(proc_rst_n, "R11 enable cleared", proc_rst_n, 1);
        ext_rst_pin_n = 1'b1;
        repeat (3) tick();
    endtask

    initial begin
        t_reset_and_first_wake();
        t_user_disabled();
        t_user_reset();
        t_retained_len();
        t_supply_over_user();
        t_len_one();
        t_backup_again();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule